// File: doc/BRIEF.md
# Periodic Rate Divider for a Real-Time Clock

This block is the divider chain of a real-time clock. It counts strobes of a 32.768 kHz reference enable in one free-running binary counter. It issues a one-clock tick once per second when that counter wraps. A 4-bit rate code picks one tap of the same counter. That tap gives a periodic event pulse, which the interrupt logic latches as a flag, and a 50% square wave for an output pin.

A 3-bit divider control field sets how the chain behaves. One code runs it on the 32.768 kHz reference. Two codes hold it cleared, so software can start the first second from a known point. All other codes stop the chain where it stands. The square wave has its own enable input.

Top module: `rtc_rate_divider`

## Requirements
- R1: While rst_ni is low, all three outputs are low and the divider counter is zero.
- R2: With div_ctl_i equal to 6 or 7, the counter is cleared on every clock. Neither tick_sec_o nor periodic_o pulses, and sqw_o falls low.
- R3: With div_ctl_i equal to 2, the counter advances by one on each clock where ref_en_i is high. It holds its value on clocks where ref_en_i is low.
- R4: With any other div_ctl_i code (0, 1, 3, 4, 5), the counter keeps its value. No tick and no periodic event is produced, and running resumes from the kept count.
- R5: tick_sec_o is high for the one clock after the strobe that brings the 15-bit count from 32767 to 0. After the clear codes are left, the first tick follows the 32768th counted strobe exactly.
- R6: For rate code n from 1 to 15, periodic_o pulses one clock after each counted strobe at which the low n-1 count bits are all ones. That is one event every 2^(n-1) strobes: code 1 fires on every strobe, and code 15 gives 2 Hz. Code 0 produces no events.
- R7: Events of every nonzero rate are phase-aligned to the second. Whenever tick_sec_o pulses and the rate code was nonzero on the previous clock, periodic_o pulses in the same clock.
- R8: With sqw_en_i high and rate code n from 2 to 15, sqw_o follows count bit n-2, one clock later. This gives a 50% duty wave with a period of 2^(n-1) strobes.
- R9: sqw_o is low one clock after sqw_en_i is low, the rate code is 0, or the rate code is 1.
- R10: A change of rate code only changes which tap is used. It takes effect on the next clock, and it does not disturb the counter or the second tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_en_i | input | 1 | One-clock strobe at the 32.768 kHz reference rate |
| div_ctl_i | input | 3 | Divider control: 2 runs, 6 and 7 clear, other codes stop |
| rate_sel_i | input | 4 | Periodic rate code, 0 disables |
| sqw_en_i | input | 1 | Square-wave output enable |
| tick_sec_o | output | 1 | One-second update tick |
| periodic_o | output | 1 | Periodic event pulse |
| sqw_o | output | 1 | Square-wave output |

## Verification
The second tick and the periodic event land in the same clock at every wrap of the counter, because each rate tap is a low-order slice of the count that rolls over at that instant. The bench sweeps all sixteen rate codes, and it keeps the counter running across each change of code. It holds code 15 and code 1 across two full seconds, so the wrap arrives with a nonzero rate selected. It judges every clock against an arithmetic strobe count: both pulses must appear together there, with neither one lost or shifted.

// File: rtl/rtc_rate_pkg.sv
package rtc_rate_pkg;
  localparam int unsigned CTL_W = 3;

  typedef enum logic [CTL_W-1:0] {
    DC_RUN   = 3'd2,
    DC_CLR_A = 3'd6,
    DC_CLR_B = 3'd7
  } div_ctl_e;

  function automatic logic is_clear(input logic [CTL_W-1:0] c);
    return (c == DC_CLR_A) || (c == DC_CLR_B);
  endfunction

  function automatic logic is_run(input logic [CTL_W-1:0] c);
    return c == DC_RUN;
  endfunction
endpackage

// File: rtl/rtc_div_chain.sv
module rtc_div_chain
  import rtc_rate_pkg::*;
#(
  parameter int unsigned DIV_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_en_i,
  input  logic [CTL_W-1:0] div_ctl_i,
  output logic [DIV_W-1:0] cnt_o,
  output logic             step_o,
  output logic             tick_sec_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             run, clr, tick_q;

  assign run    = is_run(div_ctl_i);
  assign clr    = is_clear(div_ctl_i);
  assign step_o = run & ref_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= step_o & (&cnt_q);
      if (clr)         cnt_q <= '0;
      else if (step_o) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o      = cnt_q;
  assign tick_sec_o = tick_q;

  AST_CLR_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (cnt_q == '0)); // R2
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && ref_en_i) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R3
  AST_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr && !(run && ref_en_i)) |=> $stable(cnt_q)); // R4
endmodule

// File: rtl/rtc_rate_tap.sv
module rtc_rate_tap #(
  parameter int unsigned DIV_W  = 15,
  parameter int unsigned RATE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  cnt_i,
  input  logic              step_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              periodic_o
);
  localparam int unsigned NCODE = 1 << RATE_W;

  logic [NCODE-1:0] hit;
  logic             per_q;

  // code k fires when the low k-1 count bits are all ones
  for (genvar k = 0; k < NCODE; k++) begin : g_hit
    if (k == 0) begin : g_off
      assign hit[k] = 1'b0;
    end else if (k == 1) begin : g_every
      assign hit[k] = 1'b1;
    end else if (k - 1 <= DIV_W) begin : g_tap
      assign hit[k] = &cnt_i[k-2:0];
    end else begin : g_none
      assign hit[k] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) per_q <= 1'b0;
    else         per_q <= step_i & hit[rate_i];
  end

  assign periodic_o = per_q;

  AST_RATE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_i == '0) |=> !periodic_o); // R6
  AST_NO_EVENT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> !periodic_o); // R4
endmodule

// File: rtl/rtc_sqw_gen.sv
module rtc_sqw_gen #(
  parameter int unsigned DIV_W  = 15,
  parameter int unsigned RATE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  cnt_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              en_i,
  output logic              sqw_o
);
  localparam int unsigned NCODE = 1 << RATE_W;

  logic [NCODE-1:0] tap;
  logic             sqw_q;

  // code k follows count bit k-2; codes 0 and 1 have no usable bit
  for (genvar k = 0; k < NCODE; k++) begin : g_tap
    if (k >= 2 && k - 2 < DIV_W) begin : g_bit
      assign tap[k] = cnt_i[k-2];
    end else begin : g_low
      assign tap[k] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sqw_q <= 1'b0;
    else         sqw_q <= en_i & tap[rate_i];
  end

  assign sqw_o = sqw_q;

  AST_SQW_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || rate_i < 2) |=> !sqw_o); // R9
endmodule

// File: rtl/rtc_rate_divider.sv
module rtc_rate_divider
  import rtc_rate_pkg::*;
#(
  parameter int unsigned DIV_W  = 15,
  parameter int unsigned RATE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_en_i,
  input  logic [CTL_W-1:0]  div_ctl_i,
  input  logic [RATE_W-1:0] rate_sel_i,
  input  logic              sqw_en_i,
  output logic              tick_sec_o,
  output logic              periodic_o,
  output logic              sqw_o
);
  logic [DIV_W-1:0] cnt;
  logic             step;

  rtc_div_chain #(.DIV_W(DIV_W)) u_chain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_en_i   (ref_en_i),
    .div_ctl_i  (div_ctl_i),
    .cnt_o      (cnt),
    .step_o     (step),
    .tick_sec_o (tick_sec_o)
  );

  rtc_rate_tap #(.DIV_W(DIV_W), .RATE_W(RATE_W)) u_tap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_i      (cnt),
    .step_i     (step),
    .rate_i     (rate_sel_i),
    .periodic_o (periodic_o)
  );

  rtc_sqw_gen #(.DIV_W(DIV_W), .RATE_W(RATE_W)) u_sqw (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_i  (cnt),
    .rate_i (rate_sel_i),
    .en_i   (sqw_en_i),
    .sqw_o  (sqw_o)
  );

  AST_TICK_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_sec_o && $past(rate_sel_i) != '0) |-> periodic_o); // R7
  AST_NO_TICK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_clear(div_ctl_i) |=> (!tick_sec_o && !periodic_o)); // R2
  AST_TICK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_sec_o |=> !tick_sec_o); // R5
endmodule

// File: tb/rtc_rate_divider_tb.sv
module rtc_rate_divider_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_en = 1'b0;
  logic [2:0] div_ctl = 3'd2;
  logic [3:0] rate = 4'd0;
  logic       sqw_en = 1'b0;
  logic       tick, per, sqw;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int m = 0;           // model count
  logic e_tick = 0, e_per = 0, e_sqw = 0;
  int strobes = 0;     // counted strobes since clear exit
  bit first_seen = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rtc_rate_divider u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_en_i(ref_en), .div_ctl_i(div_ctl),
    .rate_sel_i(rate), .sqw_en_i(sqw_en),
    .tick_sec_o(tick), .periodic_o(per), .sqw_o(sqw)
  );

  // arithmetic reference from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m <= 0; e_tick <= 0; e_per <= 0; e_sqw <= 0; strobes <= 0;
    end else begin
      automatic bit run  = (div_ctl == 3'd2);
      automatic bit clr  = (div_ctl == 3'd6) || (div_ctl == 3'd7);
      automatic bit step = run && ref_en;
      automatic int msk  = (rate == 0) ? 0 : (1 << (rate - 1)) - 1;
      e_tick <= step && (m == 32767);
      e_per  <= step && (rate != 0) && ((m & msk) == msk);
      e_sqw  <= sqw_en && (rate >= 2) && (((m >> (rate - 2)) & 1) == 1);
      if (clr) begin m <= 0; strobes <= 0; end
      else if (step) begin m <= (m + 1) % 32768; strobes <= strobes + 1; end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cyc=%0d act=%b exp=%b", req, cyc, act, exp);
    end
  endtask

  // R3 R5 R6 R8: every clock compared to the strobe-count model
  task automatic step_cycles(input int n, input int pat);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
      chk("R5 tick", tick, e_tick);
      chk("R6 periodic", per, e_per);
      chk("R8 sqw", sqw, e_sqw);
      if (tick && !first_seen) begin
        first_seen = 1;
        n_chk++;
        if (strobes != 32768) begin
          n_fail++;
          $display("FAIL R5 first tick after %0d strobes exp 32768", strobes);
        end
      end
      if (tick && rate != 0) chk("R7 aligned", per, 1'b1);
      ref_en = (pat <= 1) ? 1'b1 : ((cyc % pat) == 0);
    end
  endtask

  initial begin
    #1;
    chk("R1 reset tick", tick, 1'b0);
    chk("R1 reset periodic", per, 1'b0);
    chk("R1 reset sqw", sqw, 1'b0);
    repeat (3) @(negedge clk);
    chk("R1 reset hold", tick | per | sqw, 1'b0);
    div_ctl = 3'd6;
    rst_n = 1'b1;
    step_cycles(5, 1);
    div_ctl = 3'd2; rate = 4'd15; sqw_en = 1'b1;
    step_cycles(32800, 1);                     // R5 first second
    for (int r = 0; r < 16; r++) begin         // R6 R8 R10 sweep
      rate = r[3:0];
      sqw_en = (r % 3) != 2;
      step_cycles(600, (r % 4 == 3) ? 3 : 1);
    end
    div_ctl = 3'd7; rate = 4'd3;               // R2 clear
    step_cycles(40, 1);
    chk("R2 sqw low in clear", sqw, 1'b0);
    chk("R2 no tick in clear", tick | per, 1'b0);
    div_ctl = 3'd2; step_cycles(100, 1);
    for (int c = 0; c < 6; c++) begin          // R4 stop codes
      if (c == 2) continue;
      div_ctl = c[2:0];
      step_cycles(30, 1);
      chk("R4 no events when stopped", tick | per, 1'b0);
    end
    div_ctl = 3'd2; rate = 4'd1; sqw_en = 1'b1;  // R9 code 1
    step_cycles(50, 1);
    chk("R9 sqw low at code 1", sqw, 1'b0);
    rate = 4'd15; step_cycles(40000, 1);        // R7 wrap with code 15
    rate = 4'd1;  step_cycles(33000, 1);        // R7 wrap with code 1
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    while (cyc < 190000 && !done) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired at cyc=%0d", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule